// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits between a shared fetch stage and two execution pipelines. Each cycle the fetch stage hands it an ordered pair of decoded instructions, one older and one younger. The older one always goes to the U pipe, which accepts any instruction class. The younger one goes to the V pipe only when it passes every pairing rule. The V pipe takes only simple integer operations and the floating-point register exchange. The younger one must not read a register the older one writes. The two must not write the same register.

When the younger instruction cannot pair, the unit raises a hold flag. The fetch stage then presents that instruction as the older member of the next pair. A downstream stall clears both issue enables and freezes the instruction fields already presented to the pipes. All three control outputs and the routed instruction fields are registered. They appear on the clock edge after the pair is sampled.

Top module: `pair_issue_unit`

## Requirements
- R1: While reset is high, issue_u_o, issue_v_o and hold_yng_o are 0, and so are all routed payload outputs.
- R2: With stall low and the older slot valid, issue_u_o is 1 after the next edge, whatever the older class.
- R3: With stall low, both slots valid and no rule broken, issue_v_o is 1 and hold_yng_o is 0 after the next edge.
- R4: The younger instruction pairs only if its class is 0 (simple integer) or 1 (floating-point register exchange). Classes 2 (complex integer), 3 (floating-point arithmetic), 4 (load/store) and 5 (branch) give issue_v_o = 0 and hold_yng_o = 1.
- R5: Pairing is blocked (read-after-write) when the older write enable is set and either younger source index equals the older destination. It is not blocked when the older write enable is clear.
- R6: Pairing is blocked (write-after-write) when both write enables are set and the destinations are equal. It is not blocked if either write enable is clear.
- R7: Register index 0 never causes a read-after-write or write-after-write block.
- R8: With only the older slot valid, U issues alone, and issue_v_o and hold_yng_o stay 0. With no slot valid, all three are 0.
- R9: With stall high at an edge, the next outputs have both issue enables and hold at 0, and all payload outputs keep their previous values.
- R10: Whenever issue_u_o is 1, the u_* outputs carry the older slot fields sampled at that edge. Whenever issue_v_o is 1, the v_* outputs carry the younger slot fields.
- R11: A younger instruction that writes a register the older one only reads (write-after-read) still pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Downstream stall |
| old_valid_i | input | 1 | Older slot valid |
| old_cls_i | input | CLASS_W | Older instruction class |
| old_src_i | input | NUM_SRC*REG_W | Older source indices, source 0 in the low bits |
| old_dst_i | input | REG_W | Older destination index |
| old_wr_i | input | 1 | Older register-write enable |
| yng_valid_i | input | 1 | Younger slot valid |
| yng_cls_i | input | CLASS_W | Younger instruction class |
| yng_src_i | input | NUM_SRC*REG_W | Younger source indices |
| yng_dst_i | input | REG_W | Younger destination index |
| yng_wr_i | input | 1 | Younger register-write enable |
| issue_u_o | output | 1 | Issue to U pipe |
| issue_v_o | output | 1 | Issue to V pipe |
| hold_yng_o | output | 1 | Younger not issued; re-present it as older |
| u_cls_o | output | CLASS_W | Class routed to U |
| u_src_o | output | NUM_SRC*REG_W | Sources routed to U |
| u_dst_o | output | REG_W | Destination routed to U |
| u_wr_o | output | 1 | Write enable routed to U |
| v_cls_o | output | CLASS_W | Class routed to V |
| v_src_o | output | NUM_SRC*REG_W | Sources routed to V |
| v_dst_o | output | REG_W | Destination routed to V |
| v_wr_o | output | 1 | Write enable routed to V |

## Verification
The assertions assume the fetch stage never presents a valid younger slot without a valid older one. They also assume it keeps the pair steady while stalled. The bench respects both: the lone younger-valid case is never driven, and the stall test changes the pair only to show that the frozen payload ignores it. Class codes above 5 are never driven. The table exercises each hazard with its write enable both set and clear, and puts index 0 on both the read and write sides.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT_SIMPLE  = 3'd0,
    CLS_FP_XCHG     = 3'd1,
    CLS_INT_COMPLEX = 3'd2,
    CLS_FP_ARITH    = 3'd3,
    CLS_LDST        = 3'd4,
    CLS_BRANCH      = 3'd5
  } instr_cls_e;
endpackage

// File: rtl/pair_class_filter.sv
module pair_class_filter #(
  parameter int CLASS_W = pair_pkg::CLS_W
) (
  input  logic [CLASS_W-1:0] cls_i,
  output logic               v_ok_o
);
  import pair_pkg::*;

  // The restricted pipe takes only the two simple classes.
  always_comb begin
    v_ok_o = (cls_i == CLASS_W'(CLS_INT_SIMPLE)) ||
             (cls_i == CLASS_W'(CLS_FP_XCHG));
  end
endmodule

// File: rtl/pair_hazard_check.sv
module pair_hazard_check #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_W-1:0]         old_dst_i,
  input  logic                     old_wr_i,
  input  logic [NUM_SRC*REG_W-1:0] yng_src_i,
  input  logic [REG_W-1:0]         yng_dst_i,
  input  logic                     yng_wr_i,
  output logic                     raw_o,
  output logic                     waw_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic              old_writes;
  logic [NUM_SRC-1:0] src_hit;

  // A write to the hardwired register is not a real write.
  assign old_writes = old_wr_i && (old_dst_i != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = old_writes &&
                        (yng_src_i[i*REG_W +: REG_W] == old_dst_i);
  end

  assign raw_o = |src_hit;
  assign waw_o = old_writes && yng_wr_i && (yng_dst_i == old_dst_i);
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter int CLASS_W = pair_pkg::CLS_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall_i,
  input  logic                     old_valid_i,
  input  logic [CLASS_W-1:0]       old_cls_i,
  input  logic [NUM_SRC*REG_W-1:0] old_src_i,
  input  logic [REG_W-1:0]         old_dst_i,
  input  logic                     old_wr_i,
  input  logic                     yng_valid_i,
  input  logic [CLASS_W-1:0]       yng_cls_i,
  input  logic [NUM_SRC*REG_W-1:0] yng_src_i,
  input  logic [REG_W-1:0]         yng_dst_i,
  input  logic                     yng_wr_i,
  output logic                     issue_u_o,
  output logic                     issue_v_o,
  output logic                     hold_yng_o,
  output logic [CLASS_W-1:0]       u_cls_o,
  output logic [NUM_SRC*REG_W-1:0] u_src_o,
  output logic [REG_W-1:0]         u_dst_o,
  output logic                     u_wr_o,
  output logic [CLASS_W-1:0]       v_cls_o,
  output logic [NUM_SRC*REG_W-1:0] v_src_o,
  output logic [REG_W-1:0]         v_dst_o,
  output logic                     v_wr_o
);
  localparam int SRC_W = NUM_SRC * REG_W;

  logic v_class_ok;
  logic raw_hit;
  logic waw_hit;
  logic pair_ok;

  pair_class_filter #(.CLASS_W(CLASS_W)) u_filter (
    .cls_i  (yng_cls_i),
    .v_ok_o (v_class_ok)
  );

  pair_hazard_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
    .old_dst_i (old_dst_i),
    .old_wr_i  (old_wr_i),
    .yng_src_i (yng_src_i),
    .yng_dst_i (yng_dst_i),
    .yng_wr_i  (yng_wr_i),
    .raw_o     (raw_hit),
    .waw_o     (waw_hit)
  );

  assign pair_ok = old_valid_i && yng_valid_i && v_class_ok &&
                   !raw_hit && !waw_hit;

  // Control flags
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_u_o  <= 1'b0;
      issue_v_o  <= 1'b0;
      hold_yng_o <= 1'b0;
    end else begin
      issue_u_o  <= !stall_i && old_valid_i;
      issue_v_o  <= !stall_i && pair_ok;
      hold_yng_o <= !stall_i && old_valid_i && yng_valid_i && !pair_ok;
    end
  end

  // Routed payload, frozen while stalled
  always_ff @(posedge clk) begin
    if (rst) begin
      u_cls_o <= '0;
      u_src_o <= '0;
      u_dst_o <= '0;
      u_wr_o  <= 1'b0;
      v_cls_o <= '0;
      v_src_o <= '0;
      v_dst_o <= '0;
      v_wr_o  <= 1'b0;
    end else if (!stall_i) begin
      u_cls_o <= old_cls_i;
      u_src_o <= old_src_i;
      u_dst_o <= old_dst_i;
      u_wr_o  <= old_wr_i;
      v_cls_o <= yng_cls_i;
      v_src_o <= yng_src_i;
      v_dst_o <= yng_dst_i;
      v_wr_o  <= yng_wr_i;
    end
  end

  // Checks on the registered outputs
  logic v_src_reads_u;
  always_comb begin
    v_src_reads_u = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (v_src_o[i*REG_W +: REG_W] == u_dst_o) v_src_reads_u = 1'b1;
    end
  end

  AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
    issue_v_o |-> issue_u_o); // R3
  AST_V_CLASS: assert property (@(posedge clk) disable iff (rst)
    issue_v_o |-> (v_cls_o <= CLASS_W'(1))); // R4
  AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (issue_v_o && u_wr_o && (u_dst_o != '0)) |-> !v_src_reads_u); // R5
  AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (issue_v_o && u_wr_o && v_wr_o && (u_dst_o != '0)) |-> (u_dst_o != v_dst_o)); // R6
  AST_HOLD_EXCL: assert property (@(posedge clk) disable iff (rst)
    hold_yng_o |-> (issue_u_o && !issue_v_o)); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(stall_i) |-> (!issue_u_o && !issue_v_o && !hold_yng_o)); // R9
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(stall_i) |-> ($stable(u_dst_o) && $stable(v_dst_o) && $stable(v_src_o))); // R9
  AST_U_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    issue_u_o |-> (u_dst_o == $past(old_dst_i))); // R10

  localparam int UNUSED_SRC_W = SRC_W;
endmodule

// File: tb/pair_issue_unit_test.sv
module pair_issue_unit_test;
  localparam int REG_W = 5;
  localparam int NSRC  = 2;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic ov, yv, ow, yw;
  logic [CW-1:0] oc, yc;
  logic [NSRC*REG_W-1:0] os, ys;
  logic [REG_W-1:0] od, yd;
  logic iu, iv, hy, uw, vw;
  logic [CW-1:0] ucl, vcl;
  logic [NSRC*REG_W-1:0] usr, vsr;
  logic [REG_W-1:0] udst, vdst;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pair_issue_unit #(.REG_W(REG_W), .NUM_SRC(NSRC), .CLASS_W(CW)) uut (
    .clk(clk), .rst(rst), .stall_i(stall),
    .old_valid_i(ov), .old_cls_i(oc), .old_src_i(os), .old_dst_i(od), .old_wr_i(ow),
    .yng_valid_i(yv), .yng_cls_i(yc), .yng_src_i(ys), .yng_dst_i(yd), .yng_wr_i(yw),
    .issue_u_o(iu), .issue_v_o(iv), .hold_yng_o(hy),
    .u_cls_o(ucl), .u_src_o(usr), .u_dst_o(udst), .u_wr_o(uw),
    .v_cls_o(vcl), .v_src_o(vsr), .v_dst_o(vdst), .v_wr_o(vw)
  );

  typedef struct packed {
    logic       ov; logic [2:0] oc; logic [4:0] osa; logic [4:0] osb; logic [4:0] od; logic ow;
    logic       yv; logic [2:0] yc; logic [4:0] ysa; logic [4:0] ysb; logic [4:0] yd; logic yw;
    logic       eu; logic ev; logic eh;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd4,5'd5,5'd6,1'b1, 1'b1,1'b1,1'b0}, // R3 clean pair
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd3,5'd4,5'd5,5'd6,1'b1, 1'b1,1'b0,1'b1}, // R4 fp arith
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd1,5'd4,5'd5,5'd6,1'b1, 1'b1,1'b1,1'b0}, // R4 fp exchange
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd3,5'd5,5'd6,1'b1, 1'b1,1'b0,1'b1}, // R5 src0
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd4,5'd3,5'd6,1'b1, 1'b1,1'b0,1'b1}, // R5 src1
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b0, 1'b1,3'd0,5'd3,5'd5,5'd6,1'b1, 1'b1,1'b1,1'b0}, // R5 no write
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd4,5'd5,5'd3,1'b1, 1'b1,1'b0,1'b1}, // R6 waw
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd4,5'd5,5'd3,1'b0, 1'b1,1'b1,1'b0}, // R6 yng no write
    '{1'b1,3'd0,5'd1,5'd2,5'd0,1'b1, 1'b1,3'd0,5'd0,5'd0,5'd0,1'b1, 1'b1,1'b1,1'b0}, // R7 reg zero
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd0,5'd4,5'd5,5'd1,1'b1, 1'b1,1'b1,1'b0}, // R11 war
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b0,3'd0,5'd3,5'd5,5'd3,1'b1, 1'b1,1'b0,1'b0}, // R8 older only
    '{1'b0,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b0,3'd0,5'd4,5'd5,5'd6,1'b1, 1'b0,1'b0,1'b0}, // R8 none
    '{1'b1,3'd2,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd4,5'd4,5'd5,5'd6,1'b1, 1'b1,1'b0,1'b1}, // R2 R4 load
    '{1'b1,3'd3,5'd7,5'd8,5'd9,1'b1, 1'b1,3'd0,5'd4,5'd5,5'd6,1'b1, 1'b1,1'b1,1'b0}, // R2 fp on U
    '{1'b1,3'd0,5'd1,5'd2,5'd3,1'b1, 1'b1,3'd5,5'd4,5'd5,5'd6,1'b0, 1'b1,1'b0,1'b1}  // R4 branch
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ov = v.ov; oc = v.oc; os = {v.osb, v.osa}; od = v.od; ow = v.ow;
    yv = v.yv; yc = v.yc; ys = {v.ysb, v.ysa}; yd = v.yd; yw = v.yw;
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    drive(VECS[0]);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 issue_u", {31'd0, iu}, 32'd0);
    check("R1 issue_v", {31'd0, iv}, 32'd0);
    check("R1 hold", {31'd0, hy}, 32'd0);
    check("R1 u_dst", {27'd0, udst}, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k]);
      @(posedge clk); #1;
      check($sformatf("vec%0d issue_u", k), {31'd0, iu}, {31'd0, VECS[k].eu});
      check($sformatf("vec%0d issue_v", k), {31'd0, iv}, {31'd0, VECS[k].ev});
      check($sformatf("vec%0d hold", k), {31'd0, hy}, {31'd0, VECS[k].eh});
      if (VECS[k].eu) // R10
        check($sformatf("R10 vec%0d u_dst", k), {27'd0, udst}, {27'd0, VECS[k].od});
      if (VECS[k].ev) // R10
        check($sformatf("R10 vec%0d v_src", k), {22'd0, vsr}, {22'd0, VECS[k].ysb, VECS[k].ysa});
    end

    // R9 stall: present a clean pair, then stall while the inputs change
    @(negedge clk); drive(VECS[0]);
    @(posedge clk); #1;
    check("R10 u_cls", {29'd0, ucl}, 32'd0);
    @(negedge clk); stall = 1'b1; drive(VECS[13]);
    @(posedge clk); #1;
    check("R9 issue_u", {31'd0, iu}, 32'd0);
    check("R9 issue_v", {31'd0, iv}, 32'd0);
    check("R9 hold", {31'd0, hy}, 32'd0);
    check("R9 u_dst frozen", {27'd0, udst}, 32'd3);
    check("R9 v_dst frozen", {27'd0, vdst}, 32'd6);
    check("R9 u_cls frozen", {29'd0, ucl}, 32'd0);
    @(negedge clk); stall = 1'b0;
    @(posedge clk); #1;
    check("R9 release issue_u", {31'd0, iu}, 32'd1);
    check("R9 release issue_v", {31'd0, iv}, 32'd1);
    check("R10 u_dst after release", {27'd0, udst}, 32'd9);
    check("R10 v_wr", {31'd0, vw}, 32'd1);

    // R1 reset mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 re-reset issue_u", {31'd0, iu}, 32'd0);
    check("R1 re-reset u_wr", {31'd0, uw}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule